// File: doc/BRIEF.md
# Address-Space Tagged Translation Cache with Selective Invalidation

This block is a small, fully associative cache of 4 KiB page translations. Each stored line holds a 7-bit address-space identifier, the 20-bit virtual page number (virtual address bits [31:12]), a physical frame number and a set of permission bits. A lookup presents an identifier and a 32-bit virtual address and gets back, in the same cycle, a hit flag with the frame number and permissions of the matching line. A fill writes one translation into the line chosen by a round-robin pointer.

Stale translations are removed through a single 32-bit command word. The word can target every line, only the lines of one identifier, one 4 MiB section, or one 16 KiB group, and it may combine the identifier filter with either address filter. The number of lines in use can be narrowed at run time. The block is meant to sit beside a page-table walker that performs fills after misses. Software maintenance writes the command word after it edits the page tables.

Top module: `asid_tlb`

## Requirements
- R1: After reset every line is invalid, so every lookup misses, and the replacement pointer is at line 0.
- R2: A lookup hits only on a valid line below the active count whose identifier equals the lookup identifier and whose stored page equals virtual address bits [31:12]; the low 12 address bits are ignored. On a hit the frame number and permissions of the lowest-numbered matching line are returned; on a miss both outputs are zero.
- R3: A fill writes the line at the replacement pointer, and the pointer then advances by one, wrapping to 0 at the active count. If the pointer is at or above the active count when a fill arrives, the fill goes to line 0 and the pointer becomes 1.
- R4: Command bits [1:0] pick the address filter. 0 matches every address. 2 matches a line whose virtual address bits [31:22] equal command bits [19:10]. 3 matches a line whose virtual address bits [31:14] equal command bits [19:2]. 1 matches nothing.
- R5: When command bit 31 is set, only lines whose identifier equals command bits [30:24] are invalidated. When bit 31 is clear, the identifier is not compared.
- R6: An invalidation acts at the clock edge that samples the command. A lookup in that same cycle still sees the old contents, and a lookup in the next cycle misses on the invalidated lines.
- R7: When a fill and an invalidation arrive in the same cycle, the invalidation applies to the old contents first, so the newly filled line is valid afterwards.
- R8: The active count is taken from `cfg_active_lines`. A value of 0, or a value above the number of lines, means all lines are active. Lines at or above the active count never hit but keep their contents, so widening the count makes them visible again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_active_lines | input | CNT_W (4) | Number of lines in use (0 = all) |
| lk_asid | input | 7 | Lookup address-space identifier |
| lk_vaddr | input | 32 | Lookup virtual address |
| lk_hit | output | 1 | Lookup hit |
| lk_pfn | output | PFN_W (20) | Frame number of the hit line, zero on a miss |
| lk_perm | output | PERM_W (3) | Permissions of the hit line, zero on a miss |
| fill_en | input | 1 | Write one translation this cycle |
| fill_asid | input | 7 | Identifier of the new translation |
| fill_vaddr | input | 32 | Virtual address of the new translation |
| fill_pfn | input | PFN_W (20) | Frame number of the new translation |
| fill_perm | input | PERM_W (3) | Permissions of the new translation |
| flush_en | input | 1 | Apply the invalidation command this cycle |
| flush_cmd | input | 32 | Invalidation command word |

## Verification
The in-line assertions watch several properties on every cycle. A hit never comes from an inactive line, a miss always returns zeros, and the victim stays inside the active range and steps by one. A line whose identifier differs from an identifier-filtered command stays valid, a line that is filled while a command is pending survives, and a whole invalidation with no filter leaves nothing to hit. Some behaviour cannot be written as a single property and is left to the bench scenarios. These include the exact section and group address comparisons, the rule that the lowest-numbered line wins, the lookup in the same cycle as a command, and the fill that lands on line 0 after the active count shrinks below the pointer. The bench checks these against its reference model.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

  localparam int ASID_W = 7;
  localparam int VPN_W  = 20;

  typedef enum logic [1:0] {
    VM_EVERY   = 2'd0,
    VM_NONE    = 2'd1,
    VM_SECTION = 2'd2,
    VM_GROUP   = 2'd3
  } va_match_e;

  typedef struct packed {
    logic              valid;
    logic [ASID_W-1:0] asid;
    logic [VPN_W-1:0]  vpn;
  } line_tag_t;

  // Address filter of an invalidation command against a stored page number.
  function automatic logic cmd_va_match(logic [VPN_W-1:0] vpn, logic [31:0] cmd);
    case (va_match_e'(cmd[1:0]))
      VM_EVERY:   return 1'b1;
      VM_SECTION: return vpn[19:10] == cmd[19:10];
      VM_GROUP:   return vpn[19:2] == cmd[19:2];
      default:    return 1'b0;
    endcase
  endfunction

  // Identifier filter: bit 31 enables the compare against bits [30:24].
  function automatic logic cmd_asid_match(logic [ASID_W-1:0] asid, logic [31:0] cmd);
    return !cmd[31] || (asid == cmd[30:24]);
  endfunction

  // Active line count: zero or out-of-range requests mean all lines.
  function automatic int unsigned clamp_lines(int unsigned req, int unsigned total);
    return (req == 0 || req > total) ? total : req;
  endfunction

  // Round-robin successor inside [0, span).
  function automatic int unsigned rr_next(int unsigned cur, int unsigned span);
    return (cur + 1 >= span) ? 0 : cur + 1;
  endfunction

endpackage

// File: rtl/tlb_victim.sv
module tlb_victim import tlb_pkg::*; #(
  parameter int NUM_LINES = 8,
  localparam int CNT_W = $clog2(NUM_LINES + 1),
  localparam int IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cfg_lines,
  input  logic             advance,
  output logic [IDX_W-1:0] victim,
  output logic [CNT_W-1:0] active_cnt
);

  logic [IDX_W-1:0] ptr_q;
  logic [IDX_W-1:0] ptr_next;

  assign active_cnt = CNT_W'(clamp_lines(32'(cfg_lines), NUM_LINES));
  assign victim     = (CNT_W'(ptr_q) >= active_cnt) ? '0 : ptr_q;
  assign ptr_next   = IDX_W'(rr_next(32'(victim), 32'(active_cnt)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ptr_q <= '0;
    else if (advance) ptr_q <= ptr_next;
  end

  // R3: the line chosen for a fill is always an active one
  a_r3_victim_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    CNT_W'(victim) < active_cnt);

  // R3: pointer steps by one when no wrap is due
  a_r3_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
    advance && (CNT_W'(victim) + CNT_W'(1) < active_cnt)
    |=> ptr_q == IDX_W'($past(victim) + IDX_W'(1)));

  // R3: pointer wraps to zero at the end of the active range
  a_r3_ptr_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    advance && (CNT_W'(victim) + CNT_W'(1) == active_cnt) |=> ptr_q == '0);

endmodule

// File: rtl/tlb_line.sv
module tlb_line import tlb_pkg::*; #(
  parameter int PFN_W  = 20,
  parameter int PERM_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_active,
  input  logic [ASID_W-1:0] lk_asid,
  input  logic [VPN_W-1:0]  lk_vpn,
  input  logic              wr_en,
  input  logic [ASID_W-1:0] wr_asid,
  input  logic [VPN_W-1:0]  wr_vpn,
  input  logic [PFN_W-1:0]  wr_pfn,
  input  logic [PERM_W-1:0] wr_perm,
  input  logic              flush_en,
  input  logic [31:0]       flush_cmd,
  output logic              hit,
  output logic [PFN_W-1:0]  rd_pfn,
  output logic [PERM_W-1:0] rd_perm
);

  line_tag_t          tag_q;
  logic [PFN_W-1:0]   pfn_q;
  logic [PERM_W-1:0]  perm_q;
  logic               kill;
  logic               unused_cmd_bits;

  assign unused_cmd_bits = ^flush_cmd[23:20];

  assign kill = flush_en && tag_q.valid
             && cmd_asid_match(tag_q.asid, flush_cmd)
             && cmd_va_match(tag_q.vpn, flush_cmd);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tag_q  <= '0;
      pfn_q  <= '0;
      perm_q <= '0;
    end else if (wr_en) begin
      tag_q  <= '{valid: 1'b1, asid: wr_asid, vpn: wr_vpn};
      pfn_q  <= wr_pfn;
      perm_q <= wr_perm;
    end else if (kill) begin
      tag_q.valid <= 1'b0;
    end
  end

  assign hit     = line_active && tag_q.valid && (tag_q.asid == lk_asid) && (tag_q.vpn == lk_vpn);
  assign rd_pfn  = pfn_q;
  assign rd_perm = perm_q;

  // R6: a matched line is gone at the next edge
  a_r6_kill_next: assert property (@(posedge clk) disable iff (!rst_n)
    kill && !wr_en |=> !tag_q.valid);

  // R7: a fill is kept even when a command is applied in the same cycle
  a_r7_fill_survives: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && flush_en |=> tag_q.valid && tag_q.vpn == $past(wr_vpn));

  // R5: an identifier-filtered command spares other identifiers
  a_r5_other_asid_kept: assert property (@(posedge clk) disable iff (!rst_n)
    flush_en && flush_cmd[31] && tag_q.valid && (tag_q.asid != flush_cmd[30:24]) && !wr_en
    |=> tag_q.valid);

endmodule

// File: rtl/asid_tlb.sv
module asid_tlb import tlb_pkg::*; #(
  parameter int NUM_LINES = 8,
  parameter int PFN_W     = 20,
  parameter int PERM_W    = 3,
  localparam int CNT_W = $clog2(NUM_LINES + 1),
  localparam int IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  cfg_active_lines,
  input  logic [ASID_W-1:0] lk_asid,
  input  logic [31:0]       lk_vaddr,
  output logic              lk_hit,
  output logic [PFN_W-1:0]  lk_pfn,
  output logic [PERM_W-1:0] lk_perm,
  input  logic              fill_en,
  input  logic [ASID_W-1:0] fill_asid,
  input  logic [31:0]       fill_vaddr,
  input  logic [PFN_W-1:0]  fill_pfn,
  input  logic [PERM_W-1:0] fill_perm,
  input  logic              flush_en,
  input  logic [31:0]       flush_cmd
);

  logic [IDX_W-1:0]     victim;
  logic [CNT_W-1:0]     active_cnt;
  logic [NUM_LINES-1:0] hit_vec;
  logic [PFN_W-1:0]     pfn_arr  [NUM_LINES];
  logic [PERM_W-1:0]    perm_arr [NUM_LINES];
  logic                 hit_any;
  logic [IDX_W-1:0]     hit_idx;
  logic                 unused_offsets;

  assign unused_offsets = ^{lk_vaddr[11:0], fill_vaddr[11:0]};

  tlb_victim #(.NUM_LINES(NUM_LINES)) u_victim (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_lines  (cfg_active_lines),
    .advance    (fill_en),
    .victim     (victim),
    .active_cnt (active_cnt)
  );

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    tlb_line #(.PFN_W(PFN_W), .PERM_W(PERM_W)) u_line (
      .clk         (clk),
      .rst_n       (rst_n),
      .line_active (CNT_W'(g) < active_cnt),
      .lk_asid     (lk_asid),
      .lk_vpn      (lk_vaddr[31:12]),
      .wr_en       (fill_en && (victim == IDX_W'(g))),
      .wr_asid     (fill_asid),
      .wr_vpn      (fill_vaddr[31:12]),
      .wr_pfn      (fill_pfn),
      .wr_perm     (fill_perm),
      .flush_en    (flush_en),
      .flush_cmd   (flush_cmd),
      .hit         (hit_vec[g]),
      .rd_pfn      (pfn_arr[g]),
      .rd_perm     (perm_arr[g])
    );
  end

  // Lowest-numbered matching line wins.
  always_comb begin
    hit_any = 1'b0;
    hit_idx = '0;
    for (int i = NUM_LINES - 1; i >= 0; i--) begin
      if (hit_vec[i]) begin
        hit_any = 1'b1;
        hit_idx = IDX_W'(i);
      end
    end
  end

  assign lk_hit  = hit_any;
  assign lk_pfn  = hit_any ? pfn_arr[hit_idx]  : '0;
  assign lk_perm = hit_any ? perm_arr[hit_idx] : '0;

  // R8: no hit comes from a line outside the active range
  a_r8_hit_active: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> CNT_W'(hit_idx) < active_cnt);

  // R2: a miss returns zeros
  a_r2_miss_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_hit |-> (lk_pfn == '0) && (lk_perm == '0));

  // R4: unfiltered whole invalidation leaves nothing to hit
  a_r4_flush_all_empty: assert property (@(posedge clk) disable iff (!rst_n)
    flush_en && !flush_cmd[31] && (flush_cmd[1:0] == 2'd0) && !fill_en |=> !lk_hit);

endmodule

// File: tb/test_asid_tlb.sv
module test_asid_tlb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  cfg_active_lines = 4'd8;
  logic [6:0]  lk_asid = '0;
  logic [31:0] lk_vaddr = '0;
  logic        lk_hit;
  logic [19:0] lk_pfn;
  logic [2:0]  lk_perm;
  logic        fill_en = 1'b0;
  logic [6:0]  fill_asid = '0;
  logic [31:0] fill_vaddr = '0;
  logic [19:0] fill_pfn = '0;
  logic [2:0]  fill_perm = '0;
  logic        flush_en = 1'b0;
  logic [31:0] flush_cmd = '0;

  int checks = 0;
  int failures = 0;
  string cur_req = "R1";

  always #4 clk = ~clk;

  asid_tlb i_asid_tlb (
    .clk(clk), .rst_n(rst_n), .cfg_active_lines(cfg_active_lines),
    .lk_asid(lk_asid), .lk_vaddr(lk_vaddr), .lk_hit(lk_hit), .lk_pfn(lk_pfn), .lk_perm(lk_perm),
    .fill_en(fill_en), .fill_asid(fill_asid), .fill_vaddr(fill_vaddr), .fill_pfn(fill_pfn),
    .fill_perm(fill_perm), .flush_en(flush_en), .flush_cmd(flush_cmd)
  );

  // Reference model: plain arrays and integers.
  bit          m_v    [8];
  bit [6:0]    m_asid [8];
  bit [31:0]   m_page [8];
  bit [19:0]   m_pfn  [8];
  bit [2:0]    m_perm [8];
  int          m_ptr;

  function automatic int span();
    return (cfg_active_lines == 0 || cfg_active_lines > 8) ? 8 : int'(cfg_active_lines);
  endfunction

  task automatic m_lookup(output bit h, output bit [19:0] p, output bit [2:0] pr);
    h = 0; p = 0; pr = 0;
    for (int i = 0; i < span(); i++) begin
      if (!h && m_v[i] && m_asid[i] == lk_asid && m_page[i] == (lk_vaddr >> 12)) begin
        h = 1; p = m_pfn[i]; pr = m_perm[i];
      end
    end
  endtask

  task automatic m_step();
    bit sel_va;
    int slot;
    if (flush_en) begin
      for (int i = 0; i < 8; i++) begin
        case (flush_cmd[1:0])
          2'd0: sel_va = 1;
          2'd2: sel_va = ((m_page[i] << 12) & 32'hFFC0_0000) == ({12'd0, flush_cmd[19:10], 10'd0} << 12);
          2'd3: sel_va = ((m_page[i] << 12) & 32'hFFFF_C000) == ({12'd0, flush_cmd[19:2], 2'd0} << 12);
          default: sel_va = 0;
        endcase
        if (sel_va && (!flush_cmd[31] || m_asid[i] == flush_cmd[30:24])) m_v[i] = 0;
      end
    end
    if (fill_en) begin
      slot = (m_ptr >= span()) ? 0 : m_ptr;
      m_v[slot] = 1; m_asid[slot] = fill_asid; m_page[slot] = fill_vaddr >> 12;
      m_pfn[slot] = fill_pfn; m_perm[slot] = fill_perm;
      m_ptr = slot + 1;
      if (m_ptr == span()) m_ptr = 0;
    end
  endtask

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h expected=%h", tag, got, exp);
    end
  endtask

  // One clock: compare outputs with the model, take the edge, update the model.
  task automatic cyc();
    bit h; bit [19:0] p; bit [2:0] pr;
    #1;
    m_lookup(h, p, pr);
    check({cur_req, " model hit"}, 32'(lk_hit), 32'(h));
    check({cur_req, " model pfn"}, 32'(lk_pfn), 32'(p));
    check({cur_req, " model perm"}, 32'(lk_perm), 32'(pr));
    @(posedge clk);
    if (rst_n) m_step();
    @(negedge clk);
    fill_en = 0; flush_en = 0; flush_cmd = 0;
  endtask

  task automatic probe(string tag, int asid, logic [31:0] va, bit exp_hit);
    lk_asid = 7'(asid); lk_vaddr = va;
    #1 check(tag, 32'(lk_hit), 32'(exp_hit));
    cyc();
  endtask

  task automatic fill(int asid, logic [31:0] va, int pfn, int perm);
    fill_en = 1; fill_asid = 7'(asid); fill_vaddr = va; fill_pfn = 20'(pfn); fill_perm = 3'(perm);
    cyc();
  endtask

  function automatic logic [31:0] cmd_section(bit use_id, int asid, logic [31:0] va);
    return {use_id, 7'(asid), 24'd0} | ((va & 32'hFFC0_0000) >> 12) | 32'd2;
  endfunction

  function automatic logic [31:0] cmd_group(bit use_id, int asid, logic [31:0] va);
    return {use_id, 7'(asid), 24'd0} | ((va & 32'hFFFF_C000) >> 12) | 32'd3;
  endfunction

  function automatic logic [31:0] va_of(int i);
    return ((i < 4) ? 32'h1000_0000 : 32'h2040_0000) + 32'(i) * 32'h4000;
  endfunction

  function automatic int asid_of(int i);
    return (i == 6) ? 2 : i + 1;
  endfunction

  task automatic fill_set();
    for (int i = 0; i < 8; i++) fill(asid_of(i), va_of(i), 'h100 + i * 3, i);
  endtask

  initial begin
    for (int i = 0; i < 8; i++) m_v[i] = 0;
    m_ptr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;

    cur_req = "R1";
    probe("R1 empty after reset", 1, va_of(0), 0);
    check("R1 pfn zero on miss", 32'(lk_pfn), 0);

    cur_req = "R3";
    fill_set();
    cur_req = "R2";
    for (int i = 0; i < 8; i++) probe("R2 hit filled line", asid_of(i), va_of(i) | 32'h0000_0ABC, 1);
    probe("R2 wrong identifier misses", 9, va_of(3), 0);
    probe("R2 neighbouring page misses", asid_of(3), va_of(3) + 32'h1000, 0);
    lk_asid = 7'(asid_of(5)); lk_vaddr = va_of(5);
    #1 check("R2 pfn of line 5", 32'(lk_pfn), 'h100 + 15);
    check("R2 perm of line 5", 32'(lk_perm), 5);
    cyc();

    cur_req = "R6";
    lk_asid = 7'(asid_of(4)); lk_vaddr = va_of(4);
    flush_en = 1; flush_cmd = cmd_section(1, asid_of(4), va_of(4));
    #1 check("R6 same-cycle lookup sees old line", 32'(lk_hit), 1);
    cyc();
    probe("R6 section+identifier flush removed line 4", asid_of(4), va_of(4), 0);
    probe("R5 same section other identifier kept", asid_of(5), va_of(5), 1);

    cur_req = "R4";
    flush_en = 1; flush_cmd = cmd_section(0, 0, va_of(0)); cyc();
    for (int i = 0; i < 4; i++) probe("R4 section flush removed", asid_of(i), va_of(i), 0);
    probe("R4 other section kept", asid_of(6), va_of(6), 1);

    cur_req = "R5";
    flush_en = 1; flush_cmd = cmd_group(1, 99, va_of(7)); cyc();
    probe("R5 group flush wrong identifier keeps", asid_of(7), va_of(7), 1);
    flush_en = 1; flush_cmd = cmd_group(1, asid_of(5), va_of(5)); cyc();
    probe("R4 group flush removed line 5", asid_of(5), va_of(5), 0);
    probe("R4 group flush spared line 7", asid_of(7), va_of(7), 1);

    cur_req = "R4";
    flush_en = 1; flush_cmd = 32'h0000_0001 | ((va_of(7) & 32'hFFFF_C000) >> 12); cyc();
    probe("R4 type 1 removes nothing", asid_of(7), va_of(7), 1);

    cur_req = "R5";
    flush_en = 1; flush_cmd = {1'b1, 7'd2, 24'd0}; cyc();
    probe("R5 identifier-only flush removed line 6", 2, va_of(6), 0);
    probe("R5 identifier-only flush spared line 7", asid_of(7), va_of(7), 1);

    cur_req = "R4";
    flush_en = 1; flush_cmd = 32'd0; cyc();
    probe("R4 whole flush empties", asid_of(7), va_of(7), 0);

    cur_req = "R8";
    fill_set();
    cfg_active_lines = 4;
    probe("R8 inactive line does not hit", asid_of(5), va_of(5), 0);
    probe("R8 active line hits", asid_of(2), va_of(2), 1);
    cfg_active_lines = 0;
    probe("R8 zero means all lines", asid_of(5), va_of(5), 1);
    cfg_active_lines = 12;
    probe("R8 oversize means all lines", asid_of(7), va_of(7), 1);

    cur_req = "R3";
    cfg_active_lines = 8;
    for (int i = 0; i < 6; i++) fill(40 + i, 32'h3000_0000 + 32'(i) * 32'h1000, 'h200 + i, 1);
    cfg_active_lines = 4;
    fill(50, 32'h4000_0000, 'h2AA, 2);
    probe("R3 pointer beyond range fills line 0", 50, 32'h4000_0000, 1);
    probe("R3 old line 0 overwritten", 40, 32'h3000_0000, 0);
    fill(51, 32'h4000_1000, 'h2BB, 3);
    probe("R3 next fill went to line 1", 41, 32'h3000_1000, 0);
    probe("R3 line 2 untouched", 42, 32'h3000_2000, 1);

    cur_req = "R7";
    cfg_active_lines = 8;
    flush_en = 1; flush_cmd = 32'd0;
    fill(60, 32'h5000_0000, 'h777, 7);
    probe("R7 fill beside flush survives", 60, 32'h5000_0000, 1);
    probe("R7 flush still removed others", 50, 32'h4000_0000, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog got=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule